// File: doc/BRIEF.md
# ASID-Qualified Breakpoint Comparator

This block watches the stream of retired instruction addresses and the stream of operand accesses of a processor core and flags any that match a set of programmed breakpoints. Each address can be widened with an 8-bit address-space identifier (ASID), so a breakpoint can name one location inside one particular virtual address space instead of the same location in every space.

There are several instruction breakpoints, each holding an address and an ASID, and one operand breakpoint that holds an address, an ASID, a data value and a per-byte compare mask. Per-breakpoint control bits choose whether the breakpoint is armed, whether its ASID takes part in the comparison and, for the operand breakpoint, whether the data must match as well. A narrow write port loads all of this state. The hit flags are combinational on the current inputs. A registered trigger pulse follows any hit by one cycle, for use by sequencing or halt logic further downstream.

Top module: `asid_bkpt_unit`

## Requirements
- R1: A synchronous reset clears every breakpoint register and every control bit. In the cycles after reset, no hit flag and no trigger rises, even when the inputs match the cleared values (address 0, ASID 0).
- R2: Instruction breakpoint i flags `pc_hit[i]` in the same cycle as its inputs only when it is enabled, `ifetch_valid` is high and `ifetch_addr` equals its stored address. If any of these conditions is false, the flag stays low.
- R3: When the ASID-include bit of instruction breakpoint i is set, `ifetch_asid` must also equal its stored ASID. When the bit is clear, the ASID input has no effect on the hit.
- R4: The operand breakpoint flags `op_hit` only when it is enabled, `op_valid` is high, `op_addr` matches, and either its ASID-include bit is clear or `op_asid` equals its stored ASID.
- R5: When data qualification is on, each operand data byte b whose mask bit b is set must equal byte b of the stored data (byte b is bits 8b+7..8b), and bytes whose mask bit is clear are ignored. When data qualification is off, `op_data` has no effect.
- R6: `trig` is high in cycle N+1 exactly when at least one hit flag was high in cycle N. A single hitting cycle gives a trigger that lasts exactly one cycle.
- R7: A write presented in cycle N is captured on the closing clock edge. Comparisons use the new value from cycle N+1 on, and not in cycle N.
- R8: Write map, by `wr_addr`: 0..7 = address of instruction breakpoint i; 8..15 = ASID of instruction breakpoint i-8 (data bits 7:0); 16 = operand address; 17 = operand data; 18 = operand byte mask (bits 3:0) and operand ASID (bits 15:8); 19 = control, with instruction enables in bits 0..3, instruction ASID-include in bits 8..11, operand enable in bit 16, operand ASID-include in bit 17 and data qualification in bit 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register select (see R8) |
| wr_data | input | 32 | Write data |
| ifetch_valid | input | 1 | Retired instruction address is valid |
| ifetch_addr | input | 32 | Instruction address |
| ifetch_asid | input | 8 | Instruction ASID |
| op_valid | input | 1 | Operand access is valid |
| op_addr | input | 32 | Operand address |
| op_data | input | 32 | Operand data |
| op_asid | input | 8 | Operand ASID |
| pc_hit | output | 4 | Per-instruction-breakpoint hit flags |
| op_hit | output | 1 | Operand breakpoint hit flag |
| trig | output | 1 | Registered trigger pulse |

## Verification
The bench targets the ASID-include bits in both states with a mismatching ASID. A design that always compared the ASID would miss a hit when the bit is clear, and one that never compared it would fire a false hit when the bit is set. Operand data is driven with differences placed first in a masked byte and then in an unmasked byte, which exposes a mask applied to the wrong byte lanes or inverted. The bench enables a breakpoint in the same cycle that a matching address arrives, which catches a write that takes effect too early. It also follows a one-cycle hit through the trigger, which catches a trigger that is combinational or that stretches over more than one cycle.

// File: rtl/asid_bkpt_pkg.sv
package asid_bkpt_pkg;

   // register select width and map
   localparam int unsigned MAP_W        = 5;
   localparam int unsigned MAX_PC       = 8;
   localparam logic [MAP_W-1:0] SEL_PC_ADDR = 5'd0;
   localparam logic [MAP_W-1:0] SEL_PC_ASID = 5'd8;
   localparam logic [MAP_W-1:0] SEL_OP_ADDR = 5'd16;
   localparam logic [MAP_W-1:0] SEL_OP_DATA = 5'd17;
   localparam logic [MAP_W-1:0] SEL_OP_MASK = 5'd18;
   localparam logic [MAP_W-1:0] SEL_CTRL    = 5'd19;

   // control word layout
   localparam int unsigned CTL_PC_EN  = 0;
   localparam int unsigned CTL_PC_INC = 8;
   localparam int unsigned CTL_OP_EN  = 16;
   localparam int unsigned CTL_OP_INC = 17;
   localparam int unsigned CTL_OP_DQ  = 18;

   // mask register layout
   localparam int unsigned MSK_ASID_LSB = 8;

   typedef struct packed {
      logic en;
      logic asid_inc;
      logic data_qual;
   } op_ctl_t;

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
   import asid_bkpt_pkg::*;
#(
   parameter int unsigned NUM_PC = 4,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned ASID_W = 8,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned NB    = DATA_W / 8
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr_en,
   input  logic [MAP_W-1:0]               wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [NUM_PC-1:0][ADDR_W-1:0]  pc_addr_q,
   output logic [NUM_PC-1:0][ASID_W-1:0]  pc_asid_q,
   output logic [NUM_PC-1:0]              pc_en_q,
   output logic [NUM_PC-1:0]              pc_inc_q,
   output logic [ADDR_W-1:0]              op_addr_q,
   output logic [ASID_W-1:0]              op_asid_q,
   output logic [DATA_W-1:0]              op_data_q,
   output logic [NB-1:0]                  op_mask_q,
   output op_ctl_t                        op_ctl_q
);

   // per-breakpoint address and ASID storage
   for (genvar i = 0; i < NUM_PC; i++) begin : g_pc
      localparam logic [MAP_W-1:0] A_SEL = SEL_PC_ADDR + MAP_W'(i);
      localparam logic [MAP_W-1:0] S_SEL = SEL_PC_ASID + MAP_W'(i);

      always_ff @(posedge clk) begin
         if (rst) begin
            pc_addr_q[i] <= '0;
            pc_asid_q[i] <= '0;
         end else if (wr_en) begin
            if (wr_addr == A_SEL) pc_addr_q[i] <= wr_data[ADDR_W-1:0];
            if (wr_addr == S_SEL) pc_asid_q[i] <= wr_data[ASID_W-1:0];
         end
      end
   end

   // operand breakpoint and control word
   always_ff @(posedge clk) begin
      if (rst) begin
         op_addr_q <= '0;
         op_asid_q <= '0;
         op_data_q <= '0;
         op_mask_q <= '0;
         op_ctl_q  <= '0;
         pc_en_q   <= '0;
         pc_inc_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            SEL_OP_ADDR: op_addr_q <= wr_data[ADDR_W-1:0];
            SEL_OP_DATA: op_data_q <= wr_data;
            SEL_OP_MASK: begin
               op_mask_q <= wr_data[NB-1:0];
               op_asid_q <= wr_data[MSK_ASID_LSB +: ASID_W];
            end
            SEL_CTRL: begin
               pc_en_q            <= wr_data[CTL_PC_EN  +: NUM_PC];
               pc_inc_q           <= wr_data[CTL_PC_INC +: NUM_PC];
               op_ctl_q.en        <= wr_data[CTL_OP_EN];
               op_ctl_q.asid_inc  <= wr_data[CTL_OP_INC];
               op_ctl_q.data_qual <= wr_data[CTL_OP_DQ];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/bkpt_pc_cmp.sv
module bkpt_pc_cmp #(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned ASID_W       = 8,
   parameter bit          ASID_SUPPORT = 1'b1
) (
   input  logic              en,
   input  logic              asid_inc,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [ASID_W-1:0] ref_asid,
   input  logic              cur_valid,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [ASID_W-1:0] cur_asid,
   output logic              hit
);

   logic addr_eq;
   logic asid_ok;

   assign addr_eq = (ref_addr == cur_addr);

   if (ASID_SUPPORT) begin : g_asid
      assign asid_ok = !asid_inc || (ref_asid == cur_asid);
   end else begin : g_noasid
      logic unused_asid;
      assign unused_asid = ^{asid_inc, ref_asid, cur_asid};
      assign asid_ok     = 1'b1;
   end

   assign hit = en && cur_valid && addr_eq && asid_ok;

endmodule

// File: rtl/bkpt_op_cmp.sv
module bkpt_op_cmp
   import asid_bkpt_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned ASID_W       = 8,
   parameter int unsigned DATA_W       = 32,
   parameter bit          ASID_SUPPORT = 1'b1,
   localparam int unsigned NB          = DATA_W / 8
) (
   input  op_ctl_t           ctl,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [ASID_W-1:0] ref_asid,
   input  logic [DATA_W-1:0] ref_data,
   input  logic [NB-1:0]     ref_mask,
   input  logic              cur_valid,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic [DATA_W-1:0] cur_data,
   output logic              hit
);

   logic [NB-1:0] byte_ok;
   logic          data_ok;
   logic          asid_ok;
   logic          addr_eq;

   // each lane passes when unmasked or equal
   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign byte_ok[b] = !ref_mask[b] || (ref_data[8*b +: 8] == cur_data[8*b +: 8]);
   end

   assign data_ok = !ctl.data_qual || (&byte_ok);
   assign addr_eq = (ref_addr == cur_addr);

   if (ASID_SUPPORT) begin : g_asid
      assign asid_ok = !ctl.asid_inc || (ref_asid == cur_asid);
   end else begin : g_noasid
      logic unused_asid;
      assign unused_asid = ^{ctl.asid_inc, ref_asid, cur_asid};
      assign asid_ok     = 1'b1;
   end

   assign hit = ctl.en && cur_valid && addr_eq && asid_ok && data_ok;

endmodule

// File: rtl/bkpt_trig.sv
module bkpt_trig #(
   parameter int unsigned N_SRC = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_SRC-1:0] hits,
   output logic             trig
);

   always_ff @(posedge clk) begin
      if (rst) trig <= 1'b0;
      else     trig <= |hits;
   end

endmodule

// File: rtl/asid_bkpt_unit.sv
module asid_bkpt_unit
   import asid_bkpt_pkg::*;
#(
   parameter int unsigned NUM_PC       = 4,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned ASID_W       = 8,
   parameter int unsigned DATA_W       = 32,
   parameter bit          ASID_SUPPORT = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [4:0]         wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               ifetch_valid,
   input  logic [ADDR_W-1:0]  ifetch_addr,
   input  logic [ASID_W-1:0]  ifetch_asid,
   input  logic               op_valid,
   input  logic [ADDR_W-1:0]  op_addr,
   input  logic [DATA_W-1:0]  op_data,
   input  logic [ASID_W-1:0]  op_asid,
   output logic [NUM_PC-1:0]  pc_hit,
   output logic               op_hit,
   output logic               trig
);

   localparam int unsigned NB    = DATA_W / 8;
   localparam int unsigned N_SRC = NUM_PC + 1;

   // elaboration checks on the parameter set
   if (NUM_PC < 1 || NUM_PC > MAX_PC) begin : g_bad_num
      $error("NUM_PC must lie in 1..%0d", MAX_PC);
   end
   if (DATA_W % 8 != 0 || DATA_W < 24 || DATA_W > 64) begin : g_bad_data
      $error("DATA_W must be a byte multiple within 24..64");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("ADDR_W may not exceed DATA_W");
   end
   if (ASID_W < 1 || ASID_W > 8) begin : g_bad_asid
      $error("ASID_W must lie in 1..8");
   end

   logic [NUM_PC-1:0][ADDR_W-1:0] pc_addr_q;
   logic [NUM_PC-1:0][ASID_W-1:0] pc_asid_q;
   logic [NUM_PC-1:0]             pc_en_q;
   logic [NUM_PC-1:0]             pc_inc_q;
   logic [ADDR_W-1:0]             op_addr_q;
   logic [ASID_W-1:0]             op_asid_q;
   logic [DATA_W-1:0]             op_data_q;
   logic [NB-1:0]                 op_mask_q;
   op_ctl_t                       op_ctl_q;

   bkpt_regs #(
      .NUM_PC (NUM_PC),
      .ADDR_W (ADDR_W),
      .ASID_W (ASID_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .pc_addr_q (pc_addr_q),
      .pc_asid_q (pc_asid_q),
      .pc_en_q   (pc_en_q),
      .pc_inc_q  (pc_inc_q),
      .op_addr_q (op_addr_q),
      .op_asid_q (op_asid_q),
      .op_data_q (op_data_q),
      .op_mask_q (op_mask_q),
      .op_ctl_q  (op_ctl_q)
   );

   for (genvar i = 0; i < NUM_PC; i++) begin : g_pc
      bkpt_pc_cmp #(
         .ADDR_W       (ADDR_W),
         .ASID_W       (ASID_W),
         .ASID_SUPPORT (ASID_SUPPORT)
      ) u_cmp (
         .en        (pc_en_q[i]),
         .asid_inc  (pc_inc_q[i]),
         .ref_addr  (pc_addr_q[i]),
         .ref_asid  (pc_asid_q[i]),
         .cur_valid (ifetch_valid),
         .cur_addr  (ifetch_addr),
         .cur_asid  (ifetch_asid),
         .hit       (pc_hit[i])
      );
   end

   bkpt_op_cmp #(
      .ADDR_W       (ADDR_W),
      .ASID_W       (ASID_W),
      .DATA_W       (DATA_W),
      .ASID_SUPPORT (ASID_SUPPORT)
   ) u_op (
      .ctl       (op_ctl_q),
      .ref_addr  (op_addr_q),
      .ref_asid  (op_asid_q),
      .ref_data  (op_data_q),
      .ref_mask  (op_mask_q),
      .cur_valid (op_valid),
      .cur_addr  (op_addr),
      .cur_asid  (op_asid),
      .cur_data  (op_data),
      .hit       (op_hit)
   );

   bkpt_trig #(
      .N_SRC (N_SRC)
   ) u_trig (
      .clk  (clk),
      .rst  (rst),
      .hits ({op_hit, pc_hit}),
      .trig (trig)
   );

endmodule

// File: rtl/asid_bkpt_chk.sv
module asid_bkpt_chk #(
   parameter int unsigned NUM_PC = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              ifetch_valid,
   input logic              op_valid,
   input logic [NUM_PC-1:0] pc_hit,
   input logic              op_hit,
   input logic              trig
);

   // R6
   trig_follows_hit_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (trig == $past(|{op_hit, pc_hit})));

   // R2
   pc_hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (pc_hit != '0) |-> ifetch_valid);

   // R4
   op_hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      op_hit |-> op_valid);

   // R1
   quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pc_hit == '0 && !op_hit && !trig));

   // R6
   trig_single_source_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(trig) |-> $past(|{op_hit, pc_hit}));

endmodule

bind asid_bkpt_unit asid_bkpt_chk #(.NUM_PC(NUM_PC)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .ifetch_valid (ifetch_valid),
   .op_valid     (op_valid),
   .pc_hit       (pc_hit),
   .op_hit       (op_hit),
   .trig         (trig)
);

// File: tb/asid_bkpt_unit_test.sv
module asid_bkpt_unit_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        ifetch_valid = 1'b0;
   logic [31:0] ifetch_addr = '0;
   logic [7:0]  ifetch_asid = '0;
   logic        op_valid = 1'b0;
   logic [31:0] op_addr = '0;
   logic [31:0] op_data = '0;
   logic [7:0]  op_asid = '0;
   logic [3:0]  pc_hit;
   logic        op_hit;
   logic        trig;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   asid_bkpt_unit uut (
      .clk (clk), .rst (rst),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .ifetch_valid (ifetch_valid), .ifetch_addr (ifetch_addr), .ifetch_asid (ifetch_asid),
      .op_valid (op_valid), .op_addr (op_addr), .op_data (op_data), .op_asid (op_asid),
      .pc_hit (pc_hit), .op_hit (op_hit), .trig (trig)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // write lands on the posedge between two negedges (R8 map)
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle;
      #1;
   endtask

   task automatic idle_inputs;
      ifetch_valid = 1'b0; op_valid = 1'b0;
   endtask

   task automatic do_reset;
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_reset;
      do_reset();
      ifetch_valid = 1'b1; ifetch_addr = '0; ifetch_asid = '0;
      op_valid = 1'b1; op_addr = '0; op_asid = '0; op_data = '0;
      settle();
      check("R1 pc_hit after reset", 32'(pc_hit), 32'h0);
      check("R1 op_hit after reset", 32'(op_hit), 32'h0);
      @(negedge clk);
      check("R1 trig after reset", 32'(trig), 32'h0);
      idle_inputs();
   endtask

   task automatic t_pc_addr_only;
      wr(5'd1, 32'h0000_1000);
      wr(5'd9, 32'h0000_0022);
      wr(5'd19, 32'h0000_0002);        // enable bp1, ASID excluded
      ifetch_valid = 1'b1; ifetch_addr = 32'h1000; ifetch_asid = 8'h55;
      settle();
      check("R3 asid ignored when excluded", 32'(pc_hit), 32'h2);
      ifetch_addr = 32'h1004; settle();
      check("R2 address mismatch", 32'(pc_hit), 32'h0);
      ifetch_addr = 32'h1000; ifetch_valid = 1'b0; settle();
      check("R2 valid low", 32'(pc_hit), 32'h0);
      idle_inputs();
   endtask

   task automatic t_pc_asid;
      wr(5'd19, 32'h0000_0202);        // enable bp1, include ASID of bp1
      ifetch_valid = 1'b1; ifetch_addr = 32'h1000; ifetch_asid = 8'h55;
      settle();
      check("R3 asid mismatch included", 32'(pc_hit), 32'h0);
      ifetch_asid = 8'h22; settle();
      check("R3 asid match included", 32'(pc_hit), 32'h2);
      wr(5'd19, 32'h0000_0200);        // include set but not enabled
      settle();
      check("R2 disabled breakpoint", 32'(pc_hit), 32'h0);
      idle_inputs();
   endtask

   task automatic t_pc_multi;
      wr(5'd0, 32'hDEAD_0000);
      wr(5'd3, 32'hDEAD_0000);
      wr(5'd11, 32'h0000_0033);
      wr(5'd19, 32'h0000_0809);        // enable bp0,bp3; bp3 includes ASID
      ifetch_valid = 1'b1; ifetch_addr = 32'hDEAD_0000; ifetch_asid = 8'h33;
      settle();
      check("R2 two breakpoints hit", 32'(pc_hit), 32'h9);
      ifetch_asid = 8'h34; settle();
      check("R3 only asid-free bp hits", 32'(pc_hit), 32'h1);
      idle_inputs();
   endtask

   task automatic t_operand;
      wr(5'd16, 32'h0000_8000);
      wr(5'd17, 32'hAABB_CCDD);
      wr(5'd18, 32'h0000_0703);        // bytes 0,1 compared, ASID 07
      wr(5'd19, 32'h0007_0000);        // op enable, ASID include, data qualify
      op_valid = 1'b1; op_addr = 32'h8000; op_asid = 8'h07; op_data = 32'h1122_CCDD;
      settle();
      check("R5 unmasked bytes ignored", 32'(op_hit), 32'h1);
      op_data = 32'h1122_CCDE; settle();
      check("R5 masked byte differs", 32'(op_hit), 32'h0);
      op_data = 32'hAABB_CDDD; settle();
      check("R5 byte 1 differs", 32'(op_hit), 32'h0);
      op_asid = 8'h08; op_data = 32'hAABB_CCDD; settle();
      check("R4 op asid mismatch", 32'(op_hit), 32'h0);
      wr(5'd19, 32'h0005_0000);        // op enable, data qualify, no ASID
      settle();
      check("R4 op asid excluded", 32'(op_hit), 32'h1);
      wr(5'd19, 32'h0001_0000);        // op enable only
      op_data = 32'h0000_0000; settle();
      check("R5 data ignored unqualified", 32'(op_hit), 32'h1);
      op_addr = 32'h8004; settle();
      check("R4 op address mismatch", 32'(op_hit), 32'h0);
      op_addr = 32'h8000; op_valid = 1'b0; settle();
      check("R4 op valid low", 32'(op_hit), 32'h0);
      idle_inputs();
   endtask

   task automatic t_trigger;
      wr(5'd19, 32'h0000_0001);        // only bp0 (DEAD_0000)
      @(negedge clk);
      ifetch_valid = 1'b1; ifetch_addr = 32'hDEAD_0000;
      settle();
      check("R6 trig not same cycle", 32'(trig), 32'h0);
      @(negedge clk);
      ifetch_valid = 1'b0;
      settle();
      check("R6 trig next cycle", 32'(trig), 32'h1);
      @(negedge clk);
      check("R6 trig one cycle only", 32'(trig), 32'h0);
   endtask

   task automatic t_write_timing;
      wr(5'd2, 32'h0000_4444);
      ifetch_valid = 1'b1; ifetch_addr = 32'h4444; ifetch_asid = 8'h00;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'd19; wr_data = 32'h0000_0004;
      settle();
      check("R7 write not yet effective", 32'(pc_hit), 32'h0);
      @(negedge clk);
      wr_en = 1'b0; settle();
      check("R7 write effective next cycle", 32'(pc_hit), 32'h4);
      check("R8 control bit 2 arms bp2", 32'(pc_hit[2]), 32'h1);
   endtask

   task automatic t_mid_reset;
      do_reset();
      ifetch_valid = 1'b1; ifetch_addr = 32'h4444;
      settle();
      check("R1 reset clears enables", 32'(pc_hit), 32'h0);
      @(negedge clk);
      check("R1 no trigger after reset", 32'(trig), 32'h0);
      idle_inputs();
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_pc_addr_only();
            t_pc_asid();
            t_pc_multi();
            t_operand();
            t_trigger();
            t_write_timing();
            t_mid_reset();
         end
         begin
            repeat (100000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule